// File: doc/BRIEF.md
# Tower-Field AES Byte Substitution Unit

This unit replaces one byte with its AES substitution value, in either direction. No 256-entry table is stored. The byte is sent through a linear change of basis into a three-level tower field, GF(((2^2)^2)^2). There it is inverted using only 2-bit and 4-bit field arithmetic, and a second linear map brings the result back to the standard byte representation. One inversion core serves both directions. The encryption direction applies the forward affine transform after the core. The decryption direction applies the inverse affine transform before the core and nothing after it.

A direction input selects the path. An optional output register gives one cycle of latency and carries a valid flag alongside the data. A round datapath can instantiate one unit per byte lane and share the same instance between encryption and decryption. The basis-change matrices and the top-level tower constant are not written out by hand. They are derived at elaboration from the field polynomial.

Top module: `aes_cf_sbox`

## Requirements
- R1: With `dir_inv` = 0, `dout` equals A(x^-1), where x^-1 is the inverse of `din` in GF(2^8) modulo x^8+x^4+x^3+x+1 and A(a) = a ^ rotl(a,1) ^ rotl(a,2) ^ rotl(a,3) ^ rotl(a,4) ^ 0x63. For example, 0x53 gives 0xED.
- R2: With `dir_inv` = 1, `dout` equals the GF(2^8) inverse of B(`din`), where B(a) = rotl(a,1) ^ rotl(a,3) ^ rotl(a,6) ^ 0x05. For example, 0xED gives 0x53.
- R3: Zero is treated as its own inverse. The forward substitution of 0x00 is 0x63, and the inverse substitution of 0x63 is 0x00.
- R4: For every byte x, feeding the forward output back into the inverse direction returns x.
- R5: With the output register enabled (the default), a byte presented with `in_valid` high appears on `dout` after the next rising edge, and `out_valid` equals the `in_valid` of the previous cycle.
- R6: A synchronous active-high `rst` forces `out_valid` and `dout` to 0 while it is high, whatever the inputs are.
- R7: A cycle with `in_valid` low leaves `dout` unchanged at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `din` and `dir_inv` as valid this cycle |
| dir_inv | input | 1 | 0 selects forward substitution, 1 selects inverse |
| din | input | 8 | Byte to substitute |
| out_valid | output | 1 | Marks `dout` as holding a fresh result |
| dout | output | 8 | Substituted byte |

## Verification
All 256 byte values are swept in the forward direction and then in the inverse direction. Each result is compared with a bench model that finds each inverse by exhaustive multiplication. Any single wrong entry in the basis change, the subfield arithmetic or either affine transform therefore shows up. The zero byte and 0x63 are tagged separately, because only these inputs exercise the no-inverse case. A third sweep feeds the captured forward outputs back in the inverse direction, which checks that the two paths pair up. Idle cycles and reset with `in_valid` held high are inserted to separate the valid pipeline and the register enable from the data path.

// File: rtl/aes_cf_sbox_pkg.sv
package aes_cf_sbox_pkg;

    typedef logic [1:0] gf4_t;
    typedef struct packed {gf4_t hi; gf4_t lo;} gf16_t;
    typedef struct packed {gf16_t hi; gf16_t lo;} tower_t;
    typedef logic [7:0][7:0] bitmat_t;   // [column] = image of basis bit

    typedef enum logic {DIR_FWD = 1'b0, DIR_INV = 1'b1} sbox_dir_e;

    localparam int          BYTE_W    = 8;
    localparam logic [7:0]  FWD_CONST = 8'h63;
    localparam logic [7:0]  INV_CONST = 8'h05;

    // GF(4), polynomial basis, w^2 = w + 1
    function automatic gf4_t gf4_mul(gf4_t a, gf4_t b);
        gf4_t p;
        p[1] = (a[1] & b[1]) ^ (a[1] & b[0]) ^ (a[0] & b[1]);
        p[0] = (a[1] & b[1]) ^ (a[0] & b[0]);
        return p;
    endfunction

    function automatic gf4_t gf4_inv(gf4_t a);
        return {a[1], a[1] ^ a[0]};
    endfunction

    function automatic gf4_t gf4_mul_w(gf4_t a);
        return {a[1] ^ a[0], a[1]};
    endfunction

    // GF(16) over GF(4), y^2 = y + w
    function automatic gf16_t gf16_mul(gf16_t a, gf16_t b);
        gf16_t p;
        gf4_t  hh;
        hh   = gf4_mul(a.hi, b.hi);
        p.hi = hh ^ gf4_mul(a.hi, b.lo) ^ gf4_mul(a.lo, b.hi);
        p.lo = gf4_mul_w(hh) ^ gf4_mul(a.lo, b.lo);
        return p;
    endfunction

    function automatic gf16_t gf16_inv(gf16_t a);
        gf16_t r;
        gf4_t  d;
        gf4_t  di;
        d    = gf4_mul_w(gf4_mul(a.hi, a.hi)) ^ gf4_mul(a.hi, a.lo) ^ gf4_mul(a.lo, a.lo);
        di   = gf4_inv(d);
        r.hi = gf4_mul(a.hi, di);
        r.lo = gf4_mul(a.hi ^ a.lo, di);
        return r;
    endfunction

    // smallest constant making z^2 + z + c irreducible over GF(16)
    function automatic gf16_t find_top_const();
        for (int c = 1; c < 16; c++) begin
            logic has_root;
            has_root = 1'b0;
            for (int z = 0; z < 16; z++) begin
                gf16_t zz;
                zz = gf16_t'(4'(z));
                if ((gf16_mul(zz, zz) ^ zz ^ 4'(c)) == 4'h0) has_root = 1'b1;
            end
            if (!has_root) return gf16_t'(4'(c));
        end
        return gf16_t'(4'h0);
    endfunction

    localparam gf16_t TOP_CONST = find_top_const();

    function automatic tower_t tower_mul(tower_t a, tower_t b);
        tower_t p;
        gf16_t  hh;
        hh   = gf16_mul(a.hi, b.hi);
        p.hi = gf16_t'(hh ^ gf16_mul(a.hi, b.lo) ^ gf16_mul(a.lo, b.hi));
        p.lo = gf16_t'(gf16_mul(hh, TOP_CONST) ^ gf16_mul(a.lo, b.lo));
        return p;
    endfunction

    function automatic logic [7:0] lin_apply(bitmat_t m, logic [7:0] x);
        logic [7:0] r;
        r = '0;
        for (int i = 0; i < BYTE_W; i++)
            if (x[i]) r = r ^ m[i];
        return r;
    endfunction

    function automatic logic [7:0] mat_row(bitmat_t m, int r);
        logic [7:0] row;
        for (int i = 0; i < BYTE_W; i++) row[i] = m[i][r];
        return row;
    endfunction

    // column i = g^i, g a tower root of x^8+x^4+x^3+x+1
    function automatic bitmat_t build_to_tower();
        bitmat_t m;
        m = '0;
        for (int g = 2; g < 256; g++) begin
            logic [8:0][7:0] pw;
            pw[0] = 8'h01;
            for (int i = 1; i < 9; i++) pw[i] = tower_mul(tower_t'(pw[i-1]), tower_t'(8'(g)));
            if ((pw[8] ^ pw[4] ^ pw[3] ^ pw[1] ^ pw[0]) == 8'h00) begin
                for (int i = 0; i < BYTE_W; i++) m[i] = pw[i];
                return m;
            end
        end
        return m;
    endfunction

    function automatic bitmat_t build_from_tower(bitmat_t to);
        bitmat_t m;
        m = '0;
        for (int b = 0; b < 256; b++) begin
            logic [7:0] y;
            y = lin_apply(to, 8'(b));
            for (int j = 0; j < BYTE_W; j++)
                if (y == (8'h01 << j)) m[j] = 8'(b);
        end
        return m;
    endfunction

    localparam bitmat_t MAP_TO   = build_to_tower();
    localparam bitmat_t MAP_FROM = build_from_tower(MAP_TO);

endpackage

// File: rtl/sbox_lin_map.sv
module sbox_lin_map
    import aes_cf_sbox_pkg::*;
#(
    parameter bitmat_t MAT = '0
) (
    input  logic [7:0] din,
    output logic [7:0] dout
);
    for (genvar r = 0; r < BYTE_W; r++) begin : g_row
        localparam logic [7:0] ROW = mat_row(MAT, r);
        assign dout[r] = ^(din & ROW);
    end
endmodule

// File: rtl/sbox_affine.sv
module sbox_affine
    import aes_cf_sbox_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  logic [7:0] din,
    output logic [7:0] dout
);
    function automatic logic [7:0] rotl(logic [7:0] a, int k);
        return (a << k) | (a >> (BYTE_W - k));
    endfunction

    if (INVERSE) begin : g_inv
        assign dout = rotl(din, 1) ^ rotl(din, 3) ^ rotl(din, 6) ^ INV_CONST;
    end else begin : g_fwd
        assign dout = din ^ rotl(din, 1) ^ rotl(din, 2) ^ rotl(din, 3) ^ rotl(din, 4) ^ FWD_CONST;
    end
endmodule

// File: rtl/sbox_tower_inv.sv
module sbox_tower_inv
    import aes_cf_sbox_pkg::*;
(
    input  tower_t a,
    output tower_t y
);
    gf16_t norm;
    gf16_t norm_inv;

    assign norm     = gf16_t'(gf16_mul(gf16_mul(a.hi, a.hi), TOP_CONST)
                              ^ gf16_mul(a.hi, a.lo) ^ gf16_mul(a.lo, a.lo));
    assign norm_inv = gf16_inv(norm);
    assign y.hi     = gf16_mul(a.hi, norm_inv);
    assign y.lo     = gf16_mul(gf16_t'(a.hi ^ a.lo), norm_inv);

    always_comb begin
        // R1
        inv_product_chk: assert ((a == '0) || (tower_mul(a, y) == tower_t'(8'h01)))
            else $error("tower inverse product is not one");
        // R3
        inv_zero_chk: assert ((a != '0) || (y == '0))
            else $error("tower inverse of zero is not zero");
    end
endmodule

// File: rtl/aes_cf_sbox.sv
module aes_cf_sbox
    import aes_cf_sbox_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       dir_inv,
    input  logic [7:0] din,
    output logic       out_valid,
    output logic [7:0] dout
);
    sbox_dir_e  dir;
    logic [7:0] pre_aff;
    logic [7:0] core_in;
    tower_t     tow_in;
    tower_t     tow_out;
    logic [7:0] core_out;
    logic [7:0] post_aff;
    logic [7:0] result;

    assign dir = sbox_dir_e'(dir_inv);

    sbox_affine #(.INVERSE(1'b1)) u_pre_aff (.din(din), .dout(pre_aff));

    assign core_in = (dir == DIR_INV) ? pre_aff : din;

    sbox_lin_map #(.MAT(MAP_TO))   u_to   (.din(core_in), .dout(tow_in));
    sbox_tower_inv                 u_inv  (.a(tow_in), .y(tow_out));
    sbox_lin_map #(.MAT(MAP_FROM)) u_from (.din(tow_out), .dout(core_out));

    sbox_affine #(.INVERSE(1'b0)) u_post_aff (.din(core_out), .dout(post_aff));

    assign result = (dir == DIR_INV) ? core_out : post_aff;

    always_comb begin
        // R1
        map_roundtrip_chk: assert (lin_apply(MAP_FROM, tow_in) == core_in)
            else $error("basis change does not invert");
        // R3
        zero_fwd_chk: assert (!(dir == DIR_FWD && din == 8'h00) || result == FWD_CONST)
            else $error("forward of zero wrong");
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                out_valid <= 1'b0;
                dout      <= '0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) dout <= result;
            end
        end

        // R5
        valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);
        // R5
        data_latency_chk: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> (dout == $past(result)));
        // R7
        idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> $stable(dout));
    end else begin : g_comb
        assign out_valid = in_valid;
        assign dout      = result;
    end
endmodule

// File: tb/aes_cf_sbox_test.sv
`timescale 1ns/1ps
module aes_cf_sbox_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       dir_inv = 1'b0;
    logic [7:0] din = '0;
    logic       out_valid;
    logic [7:0] dout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit         exp_v = 1'b0;
    logic [7:0] exp_d = '0;
    string      exp_tag = "R6";
    int         exp_idx = -1;
    logic [7:0] got [256];

    always #2.5 clk = ~clk;

    aes_cf_sbox uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .dir_inv(dir_inv),
        .din(din), .out_valid(out_valid), .dout(dout)
    );

    function automatic logic [7:0] gmul(logic [7:0] a, logic [7:0] b);
        logic [7:0] p = 0;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
        end
        return p;
    endfunction

    function automatic logic [7:0] ginv(logic [7:0] a);
        for (int c = 1; c < 256; c++)
            if (gmul(a, 8'(c)) == 8'h01) return 8'(c);
        return 8'h00;
    endfunction

    function automatic logic [7:0] ref_fwd(logic [7:0] x);
        logic [7:0] a = ginv(x);
        logic [7:0] b;
        for (int i = 0; i < 8; i++)
            b[i] = a[i] ^ a[(i+4)%8] ^ a[(i+5)%8] ^ a[(i+6)%8] ^ a[(i+7)%8] ^ (8'h63 >> i) & 1'b1;
        return b;
    endfunction

    function automatic logic [7:0] ref_inv(logic [7:0] x);
        logic [7:0] b;
        for (int i = 0; i < 8; i++)
            b[i] = x[(i+2)%8] ^ x[(i+5)%8] ^ x[(i+7)%8] ^ (8'h05 >> i) & 1'b1;
        return ginv(b);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // outputs now show last cycle's inputs; then drive the next ones
    task automatic step(input bit v, input bit d, input logic [7:0] x,
                        input logic [7:0] expd, input string tag, input int idx);
        @(negedge clk);
        check(out_valid == exp_v, "R5 valid", out_valid, exp_v);
        check(dout == exp_d, exp_tag, dout, exp_d);
        if (exp_idx >= 0) got[exp_idx] = dout;
        in_valid = v; dir_inv = d; din = x;
        exp_v = v;
        if (v) begin exp_d = expd; exp_tag = tag; exp_idx = idx; end
        else begin exp_tag = "R7 hold"; exp_idx = -1; end
    endtask

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R6: reset dominates even with valid input
        rst = 1'b1; in_valid = 1'b1; dir_inv = 1'b0; din = 8'h53;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R6 valid", out_valid, 0);
        check(dout == 8'h00, "R6 data", dout, 0);
        rst = 1'b0; in_valid = 1'b0;
        exp_v = 1'b0; exp_d = 8'h00; exp_tag = "R6"; exp_idx = -1;

        // R1 / R3: full forward sweep
        for (int x = 0; x < 256; x++)
            step(1'b1, 1'b0, 8'(x), ref_fwd(8'(x)), (x == 0) ? "R3 fwd zero" : "R1 fwd", x);
        step(1'b0, 1'b0, 8'hAA, 8'h00, "", -1);                 // R7 idle
        step(1'b0, 1'b1, 8'h00, 8'h00, "", -1);                 // R7 idle

        // R1 known value, R2 known value
        step(1'b1, 1'b0, 8'h53, 8'hED, "R1 0x53", -1);
        step(1'b1, 1'b1, 8'hED, 8'h53, "R2 0xED", -1);

        // R2 / R3: full inverse sweep
        for (int x = 0; x < 256; x++)
            step(1'b1, 1'b1, 8'(x), ref_inv(8'(x)), (x == 8'h63) ? "R3 inv 0x63" : "R2 inv", -1);
        step(1'b0, 1'b0, 8'h00, 8'h00, "", -1);

        // R4: feed captured forward outputs back through inverse
        for (int x = 0; x < 256; x++)
            step(1'b1, 1'b1, got[x], 8'(x), "R4 roundtrip", -1);

        // mixed directions with gaps
        step(1'b1, 1'b0, 8'h00, 8'h63, "R3 fwd zero", -1);
        step(1'b0, 1'b1, 8'h63, 8'h00, "", -1);
        step(1'b1, 1'b1, 8'h63, 8'h00, "R3 inv 0x63", -1);
        step(1'b1, 1'b0, 8'hFF, ref_fwd(8'hFF), "R1 fwd", -1);
        step(1'b0, 1'b0, 8'h00, 8'h00, "", -1);
        step(1'b0, 1'b0, 8'h00, 8'h00, "", -1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule